// File: doc/BRIEF.md
# Decimal Partial Product Generator (5-2-2-1 Split)

This block forms one partial product of a parallel decimal multiplier. It takes a single BCD multiplier digit Y and returns Y times the multiplicand X as N+1 decimal digits. Each output digit carries a flag that says whether the digit is coded in BCD or in excess-6. The caller supplies X in BCD and two precomputed multiples: 2X in BCD and 5X in excess-6. Both multiples are one digit wider than X, and that extra top digit holds the overflow from the most significant digit of X.

Inside, the digit value is split into three terms: a five-term (0 or 5), a two-term (0 or 2) and a unit term (0, 1 or 2). Four select lines are decoded straight from the BCD bits of Y. There is no explicit conversion to a 5-2-2-1 code.

The first carry chain adds the five-term and the two-term. The five-term is either 5X or the excess-6 code of zero, and the two-term is either 2X or a BCD zero. The second carry chain adds the unit term, which is 0, X or 2X. It reads the first chain's per-digit flags as the coding of its first operand.

Both chains use a decimal digit adder with mixed coding. Its digit carry is always correct, and the same carry tells whether the sum digit is BCD or excess-6. A parameter picks either a plain ripple digit adder or a carry-select digit adder.

Top module: `dec_pp_gen`

## Requirements
- R1: For every multiplier digit Y from 0 to 9 and any valid multiplicand X, the flag-decoded output equals Y·X. The flag-decoded value is the sum over digits i of (digit_i − 6·(1 − flag_i))·10^i.
- R2: Every output digit follows its flag. When flag = 1 the digit is BCD, with code 0..9 equal to its value. When flag = 0 the digit is excess-6, with code 6..15 equal to its value plus 6.
- R3: When Y = 0, every output digit decodes to value 0, whatever X, 2X and 5X are.
- R4: When Y = 5, the X and 2X inputs have no effect on the output digits or flags.
- R5: When Y = 1, the 2X and 5X inputs have no effect on the outputs.
- R6: When Y = 2, the X and 5X inputs have no effect on the outputs.
- R7: The top digit of 2X and the top digit of 5X count at weight 10^N. For example, Y = 5 with an X whose top digit is 9 yields a top output digit worth 4.
- R8: With Y = 9 and X made of all nines, the product 9·(10^N − 1) appears exactly, with top digit value 8 and bottom digit value 1.
- R9: Y values of 4, 7 and 9 take 2X as the unit-term source, and Y values of 1, 3, 6 and 8 take X. Each of these digits yields the exact product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| y_dig | input | 4 | Multiplier digit in BCD |
| x_bcd | input | 4·N_DIG | Multiplicand X, BCD digits, digit 0 in bits 3:0 |
| x2_bcd | input | 4·(N_DIG+1) | Multiple 2X, BCD digits |
| x5_e6 | input | 4·(N_DIG+1) | Multiple 5X, excess-6 digits |
| pp_dig | output | 4·(N_DIG+1) | Partial product digits, mixed coding |
| pp_is_bcd | output | N_DIG+1 | Per-digit flag: 1 means BCD, 0 means excess-6 |

## Verification
Several behaviours are asserted on every evaluation:
- the selector decode rebuilds Y from its five, two and unit terms;
- each digit adder keeps its output code inside the range its flag allows;
- neither carry chain carries out of the top digit;
- a zero digit Y gives a zero-valued product.

Other behaviours only the directed scenarios can show:
- the exact product across all ten digits;
- the weight of the overflow digit in the multiples;
- the all-nines extreme;
- the insensitivity to unused multiples, shown by driving them with unrelated values and comparing the outputs.

// File: rtl/dec_pp_pkg.sv
package dec_pp_pkg;

   localparam int DIG_W = 4;

   // excess-6 code of decimal zero
   localparam logic [DIG_W-1:0] E6_ZERO = 4'd6;

   typedef struct packed {
      logic five;    // five-term present (value 5)
      logic two;     // two-term present (value 2)
      logic u_dbl;   // unit term uses 2X instead of X
      logic u_none;  // unit term is zero
   } sel_t;

endpackage

// File: rtl/dec_pp_sel.sv
module dec_pp_sel
   import dec_pp_pkg::*;
(
   input  logic [3:0] y,
   output sel_t       sel
);

   always_comb begin
      sel.five   = y[3] | (y[2] & (y[1] | y[0]));
      sel.two    = y[3] | (~y[2] & y[1]) | (y[2] & ~y[1] & ~y[0]);
      sel.u_none = ~y[3] & ((~y[2] & ~y[0]) | (y[2] & ~y[1] & y[0]));
      sel.u_dbl  = (y[2] & ~y[1] & ~y[0]) | (y[2] & y[1] & y[0]) | (y[3] & y[0]);
   end

   // R1: the three terms rebuild the digit
   always_comb begin
      if (y <= 4'd9) begin
         p_decomp_r1: assert ((sel.five ? 5 : 0) + (sel.two ? 2 : 0)
                              + (sel.u_none ? 0 : (sel.u_dbl ? 2 : 1)) == int'(y))
            else $error("selector decode does not rebuild digit %0d", y);
      end
   end

endmodule

// File: rtl/dec_pp_digadd.sv
module dec_pp_digadd
   import dec_pp_pkg::*;
#(
   parameter int CARRY_SEL = 0
)(
   input  logic [3:0] a,
   input  logic       a_bcd,
   input  logic [3:0] b,
   input  logic       b_bcd,
   input  logic       cin,
   output logic [3:0] sum,
   output logic       s_bcd,
   output logic       cout
);

   logic [5:0] base;
   logic [5:0] tot;

   // bias the raw code sum to w + z + 6
   always_comb begin
      base = {2'b00, a} + {2'b00, b};
      if (a_bcd && b_bcd)
         base = base + 6'd6;
      else if (!a_bcd && !b_bcd)
         base = base - 6'd6;
   end

   generate
      if (CARRY_SEL == 1) begin : g_csel
         logic [5:0] t0, t1;
         assign t0  = base;
         assign t1  = base + 6'd1;
         assign tot = cin ? t1 : t0;
      end else begin : g_ripple
         assign tot = base + {5'd0, cin};
      end
   endgenerate

   assign cout  = tot[4];
   assign sum   = tot[3:0];
   assign s_bcd = tot[4];

   // R2: the output code stays inside the range named by its flag
   always_comb begin
      if ((a_bcd ? (a <= 4'd9) : (a >= 4'd6)) && (b_bcd ? (b <= 4'd9) : (b >= 4'd6))) begin
         p_code_legal_r2: assert (s_bcd ? (sum <= 4'd9) : (sum >= 4'd6))
            else $error("digit code %0d illegal for flag %0b", sum, s_bcd);
      end
   end

endmodule

// File: rtl/dec_pp_stage.sv
module dec_pp_stage
   import dec_pp_pkg::*;
#(
   parameter int ND        = 5,
   parameter int CARRY_SEL = 0,
   localparam int W        = DIG_W * ND
)(
   input  logic [W-1:0]  a_dig,
   input  logic [ND-1:0] a_bcd,
   input  logic [W-1:0]  b_dig,
   input  logic [ND-1:0] b_bcd,
   output logic [W-1:0]  s_dig,
   output logic [ND-1:0] s_bcd,
   output logic          c_top
);

   logic [ND:0] cy;
   assign cy[0] = 1'b0;

   generate
      for (genvar i = 0; i < ND; i++) begin : g_dig
         dec_pp_digadd #(.CARRY_SEL(CARRY_SEL)) u_add (
            .a     (a_dig[DIG_W*i +: DIG_W]),
            .a_bcd (a_bcd[i]),
            .b     (b_dig[DIG_W*i +: DIG_W]),
            .b_bcd (b_bcd[i]),
            .cin   (cy[i]),
            .sum   (s_dig[DIG_W*i +: DIG_W]),
            .s_bcd (s_bcd[i]),
            .cout  (cy[i+1])
         );
      end
   endgenerate

   assign c_top = cy[ND];

endmodule

// File: rtl/dec_pp_gen.sv
module dec_pp_gen
   import dec_pp_pkg::*;
#(
   parameter int N_DIG     = 4,
   parameter int CARRY_SEL = 0,
   localparam int ND       = N_DIG + 1,
   localparam int XW       = DIG_W * N_DIG,
   localparam int PW       = DIG_W * ND
)(
   input  logic [3:0]    y_dig,
   input  logic [XW-1:0] x_bcd,
   input  logic [PW-1:0] x2_bcd,
   input  logic [PW-1:0] x5_e6,
   output logic [PW-1:0] pp_dig,
   output logic [ND-1:0] pp_is_bcd
);

   generate
      if (N_DIG < 1 || N_DIG > 17) begin : g_bad_n
         $error("N_DIG must lie in 1..17");
      end
      if (CARRY_SEL != 0 && CARRY_SEL != 1) begin : g_bad_c
         $error("CARRY_SEL must be 0 or 1");
      end
   endgenerate

   sel_t sel;

   dec_pp_sel u_sel (.y(y_dig), .sel(sel));

   // first chain: (5X or excess-6 zero) + (2X or BCD zero)
   logic [PW-1:0] s1_a, s1_b, s1_dig;
   logic [ND-1:0] s1_bcd;
   logic          s1_ctop;

   always_comb begin
      for (int i = 0; i < ND; i++) begin
         s1_a[DIG_W*i +: DIG_W] = sel.five ? x5_e6[DIG_W*i +: DIG_W] : E6_ZERO;
         s1_b[DIG_W*i +: DIG_W] = sel.two  ? x2_bcd[DIG_W*i +: DIG_W] : 4'd0;
      end
   end

   dec_pp_stage #(.ND(ND), .CARRY_SEL(CARRY_SEL)) u_stage1 (
      .a_dig (s1_a),
      .a_bcd ({ND{1'b0}}),
      .b_dig (s1_b),
      .b_bcd ({ND{1'b1}}),
      .s_dig (s1_dig),
      .s_bcd (s1_bcd),
      .c_top (s1_ctop)
   );

   // second chain: first result + (0, X or 2X) in BCD
   logic [PW-1:0] x_ext, u_mux, s2_b;
   logic          s2_ctop;

   assign x_ext = {4'd0, x_bcd};
   assign u_mux = sel.u_dbl ? x2_bcd : x_ext;
   assign s2_b  = sel.u_none ? '0 : u_mux;

   dec_pp_stage #(.ND(ND), .CARRY_SEL(CARRY_SEL)) u_stage2 (
      .a_dig (s1_dig),
      .a_bcd (s1_bcd),
      .b_dig (s2_b),
      .b_bcd ({ND{1'b1}}),
      .s_dig (pp_dig),
      .s_bcd (pp_is_bcd),
      .c_top (s2_ctop)
   );

   // R8: no carry leaves either chain for a legal digit
   always_comb begin
      if (y_dig <= 4'd9) begin
         p_no_overflow1_r8: assert (!s1_ctop)
            else $error("first chain carried out of top digit");
         p_no_overflow2_r8: assert (!s2_ctop)
            else $error("second chain carried out of top digit");
      end
   end

   // R3: zero digit gives zero-valued product
   logic all_zero;
   always_comb begin
      all_zero = 1'b1;
      for (int i = 0; i < ND; i++) begin
         if (pp_dig[DIG_W*i +: DIG_W] != (pp_is_bcd[i] ? 4'd0 : E6_ZERO))
            all_zero = 1'b0;
      end
      if (y_dig == 4'd0) begin
         p_zero_digit_r3: assert (all_zero)
            else $error("zero multiplier digit gave nonzero product");
      end
   end

endmodule

// File: tb/tb_dec_pp_gen.sv
module tb_dec_pp_gen;

   localparam int N  = 4;
   localparam int ND = N + 1;
   localparam int PW = 4 * ND;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic [3:0]     y_dig;
   logic [4*N-1:0] x_bcd;
   logic [PW-1:0]  x2_bcd, x5_e6, pp_dig;
   logic [ND-1:0]  pp_is_bcd;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   dec_pp_gen #(.N_DIG(N)) dut (
      .y_dig(y_dig), .x_bcd(x_bcd), .x2_bcd(x2_bcd), .x5_e6(x5_e6),
      .pp_dig(pp_dig), .pp_is_bcd(pp_is_bcd)
   );

   function automatic logic [PW-1:0] enc(longint v, bit e6);
      logic [PW-1:0] r;
      longint t = v;
      for (int i = 0; i < ND; i++) begin
         r[4*i +: 4] = 4'(t % 10) + (e6 ? 4'd6 : 4'd0);
         t = t / 10;
      end
      return r;
   endfunction

   function automatic longint dec_out();
      longint v = 0;
      longint w = 1;
      for (int i = 0; i < ND; i++) begin
         v = v + (longint'(pp_dig[4*i +: 4]) - (pp_is_bcd[i] ? 0 : 6)) * w;
         w = w * 10;
      end
      return v;
   endfunction

   function automatic bit codes_ok();
      for (int i = 0; i < ND; i++) begin
         if (pp_is_bcd[i] && pp_dig[4*i +: 4] > 4'd9) return 1'b0;
         if (!pp_is_bcd[i] && pp_dig[4*i +: 4] < 4'd6) return 1'b0;
      end
      return 1'b1;
   endfunction

   task automatic check(bit ok, string req, longint act, longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic drive(longint xv, int yv);
      @(negedge clk);
      y_dig  = 4'(yv);
      x_bcd  = enc(xv, 1'b0)[4*N-1:0];
      x2_bcd = enc(2 * xv, 1'b0);
      x5_e6  = enc(5 * xv, 1'b1);
      @(posedge clk);
      #1;
   endtask

   task automatic t_idle;
      drive(0, 0);
      check(dec_out() == 0, "R3 idle", dec_out(), 0);
      check(codes_ok(), "R2 idle", 0, 1);
   endtask

   task automatic t_all_digits;
      longint xs[4] = '{1234, 9999, 5070, 8};
      for (int k = 0; k < 9; k++) begin
         longint xv = (k < 4) ? xs[k] : longint'($urandom_range(0, 9999));
         for (int y = 0; y <= 9; y++) begin
            drive(xv, y);
            check(dec_out() == xv * y, "R1 product", dec_out(), xv * y);
            check(codes_ok(), "R2 code range", 0, 1);
         end
      end
   endtask

   task automatic t_unit_source;
      int ys[7] = '{4, 7, 9, 1, 3, 6, 8};
      foreach (ys[k]) begin
         drive(6173, ys[k]);
         check(dec_out() == 6173 * ys[k], "R9 unit source", dec_out(), 6173 * ys[k]);
      end
   endtask

   // perturb inputs that must not matter, compare against clean output
   task automatic t_ignore(int yv, bit px, bit p2, bit p5, string req);
      logic [PW-1:0] ref_d;
      logic [ND-1:0] ref_f;
      drive(4821, yv);
      ref_d = pp_dig;
      ref_f = pp_is_bcd;
      @(negedge clk);
      if (px) x_bcd  = enc(3907, 1'b0)[4*N-1:0];
      if (p2) x2_bcd = enc(2 * 3907, 1'b0);
      if (p5) x5_e6  = enc(5 * 3907, 1'b1);
      @(posedge clk);
      #1;
      check(pp_dig == ref_d && pp_is_bcd == ref_f, req, longint'(pp_dig), longint'(ref_d));
   endtask

   task automatic t_overflow_digit;
      drive(9000, 5);
      check(dec_out() == 45000, "R7 top digit weight", dec_out(), 45000);
      check((pp_dig[4*N +: 4] - (pp_is_bcd[N] ? 0 : 6)) == 4, "R7 top digit", pp_dig[4*N +: 4], 4);
      drive(5000, 2);
      check(dec_out() == 10000, "R7 2X top digit", dec_out(), 10000);
   endtask

   task automatic t_max;
      drive(9999, 9);
      check(dec_out() == 89991, "R8 max product", dec_out(), 89991);
      check((pp_dig[4*N +: 4] - (pp_is_bcd[N] ? 0 : 6)) == 8, "R8 top digit", pp_dig[4*N +: 4], 8);
      check((pp_dig[3:0] - (pp_is_bcd[0] ? 0 : 6)) == 1, "R8 low digit", pp_dig[3:0], 1);
      check(codes_ok(), "R2 at max", 0, 1);
   endtask

   initial begin
      y_dig = '0; x_bcd = '0; x2_bcd = '0; x5_e6 = enc(0, 1'b1);
      repeat (2) @(posedge clk);
      rst_n = 1'b1;
      t_idle();
      t_all_digits();
      t_unit_source();
      t_ignore(0, 1, 1, 1, "R3 zero ignores inputs");
      t_ignore(5, 1, 1, 0, "R4 five ignores X and 2X");
      t_ignore(1, 0, 1, 1, "R5 one ignores 2X and 5X");
      t_ignore(2, 1, 0, 1, "R6 two ignores X and 5X");
      t_overflow_digit();
      t_max();
      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         done = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule